// File: doc/BRIEF.md
# Two-Wire Regulator Control Register Slave

This block is a slave-only two-wire serial port that owns the enable and output-level selection bits for four linear regulators. A host on the bus addresses the block with a fixed 7-bit device address. It then sends one internal register index and either writes one data byte or, after a repeated START, reads one data byte back. Each access moves exactly one byte. The register bits are decoded straight onto output pins that steer the regulators.

The bus clock and data lines are brought into the system clock domain through a two-flop synchroniser. START and STOP conditions, and the clock edges, are found on the synchronised copies. The open-drain data pin is represented by an output-enable: when it is high, the pad pulls the line low. A START or STOP anywhere in a transfer abandons it. An address that is not this device's causes the block to stay silent until the next START.

Top module: `pmic_i2c_slave`

## Requirements
- R1: After reset all four regulator enables read 1 and every voltage-select output is 0. The data output-enable is low.
- R2: A first byte whose upper seven bits equal 7'b1001000 is acknowledged, and its low bit picks read (1) or write (0). Any other address is not acknowledged, and the block ignores the rest of that transfer, so a following register write has no effect.
- R3: A write sequence to index 0x00 loads the enables: bit 0 drives regulator 1, bit 1 regulator 2, bit 2 regulator 3 and bit 3 regulator 4. All enables are active high.
- R4: A write to index 0x08 sets the regulator-1 select from bit 4, the regulator-2 select from bit 3 and the 2-bit regulator-3 select from bits [2:1].
- R5: A write to index 0x0A sets the 2-bit regulator-4 select from bits [3:2].
- R6: A read uses the sequence address+W, index, repeated START, address+R. It returns the register content MSB first. Bits outside the defined fields read 0, and values written to them are discarded.
- R7: A read of any index other than 0x00, 0x08 and 0x0A returns 0xFF.
- R8: A write to an unmapped index is acknowledged and changes no output.
- R9: A STOP or START that arrives before a data byte is complete aborts the transfer with no register change.
- R10: The slave pulls data low during the ninth clock of every byte it accepts. It changes its data output-enable only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | Pull data line low when 1 |
| ldoEn | output | 4 | Regulator enables, bit i for regulator i+1 |
| ldo1Sel | output | 1 | Regulator-1 level select |
| ldo2Sel | output | 1 | Regulator-2 level select |
| ldo3Sel | output | 2 | Regulator-3 level select |
| ldo4Sel | output | 2 | Regulator-4 level select |

## Verification
Random write-then-read pairs go to a mix of the three mapped indices and arbitrary indices, with random data. This separates correct field placement and masking of unused bits from wrong bit positions, and tells mapped decode apart from the 0xFF default. Directed transfers use a foreign device address, an unmapped write and a data byte cut short by a STOP. Each must leave the outputs untouched, which distinguishes genuine ignore and abort paths from leaks into the registers. Acknowledge bits are sampled on every byte, so a missing or misplaced acknowledge shows up as well as wrong data.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_REGADDR, ST_REGACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic setAddr;
    logic writeReg;
  } dpStrobe_t;
endpackage

// File: rtl/pmic_i2c_ctrl.sv
module pmic_i2c_ctrl
  import pmic_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1001000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output logic              sdaBit,
  output dpStrobe_t         stb,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startEv, stopEv;
  busState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic rdPend, rdNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS    = sclSync[SYNC_STAGES-1];
  assign sdaS    = sdaSync[SYNC_STAGES-1];
  assign sdaBit  = sdaS;
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;

  always_comb begin
    stateNxt = state;
    cntNxt   = bitCnt;
    rdNxt    = rdPend;
    stb      = '0;
    if (stopEv) begin
      stateNxt = ST_IDLE;
    end else if (startEv) begin
      stateNxt = ST_DEVADDR;
      cntNxt   = '0;
    end else begin
      case (state)
        ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
          if (sclRise && bitCnt < FULL) begin
            stb.shiftIn = 1'b1;
            cntNxt      = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            cntNxt = '0;
            if (state == ST_DEVADDR) begin
              if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                stateNxt = ST_DEVACK;
                rdNxt    = rxByte[0];
              end else begin
                stateNxt = ST_IGNORE;
              end
            end else if (state == ST_REGADDR) begin
              stb.setAddr = 1'b1;
              stateNxt    = ST_REGACK;
            end else begin
              stb.writeReg = 1'b1;
              stateNxt     = ST_WACK;
            end
          end
        end
        ST_DEVACK: if (sclFall) begin
          if (rdPend) begin
            stateNxt   = ST_RDATA;
            stb.loadTx = 1'b1;
          end else begin
            stateNxt = ST_REGADDR;
          end
        end
        ST_REGACK: if (sclFall) stateNxt = ST_WDATA;
        ST_WACK:   if (sclFall) stateNxt = ST_IGNORE;
        ST_RDATA:  if (sclFall) begin
          if (bitCnt == LAST) begin
            stateNxt = ST_RACK;
            cntNxt   = '0;
          end else begin
            stb.shiftTx = 1'b1;
            cntNxt      = bitCnt + 1'b1;
          end
        end
        ST_RACK:   if (sclFall) stateNxt = ST_IGNORE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rdPend <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= cntNxt;
      rdPend <= rdNxt;
    end
  end

  always_comb begin
    case (state)
      ST_DEVACK, ST_REGACK, ST_WACK: sdaOe = 1'b1;
      ST_RDATA:                      sdaOe = ~txMsb;
      default:                       sdaOe = 1'b0;
    endcase
  end

  // R2: acknowledge phase only after a matching address byte
  a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEVACK && $past(state) == ST_DEVADDR) |-> rxByte[BYTE_W-1:1] == DEV_ADDR);
  // R10: pad drive changes only while bus clock is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);
  // R9: a STOP releases the line
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);
  // R6: bit counter never passes a full byte
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);
endmodule

// File: rtl/pmic_i2c_regs.sv
module pmic_i2c_regs
  import pmic_i2c_pkg::*;
#(
  parameter int          NUM_LDO    = 4,
  parameter logic [7:0]  ADDR_CTRL  = 8'h00,
  parameter logic [7:0]  ADDR_TRIM1 = 8'h08,
  parameter logic [7:0]  ADDR_TRIM4 = 8'h0A
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic               sdaBit,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               txMsb,
  output logic [NUM_LDO-1:0] ldoEn,
  output logic               ldo1Sel,
  output logic               ldo2Sel,
  output logic [1:0]         ldo3Sel,
  output logic [1:0]         ldo4Sel
);
  localparam int T1_LSB = 1;
  localparam int T1_W   = 4;
  localparam int T4_LSB = 2;
  localparam int T4_W   = 2;

  logic [BYTE_W-1:0]  shiftReg, txReg, regAddr, readByte;
  logic [NUM_LDO-1:0] ctrlReg;
  logic [T1_W-1:0]    trim1;
  logic [T4_W-1:0]    trim4;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      txReg    <= '1;
      regAddr  <= '0;
      ctrlReg  <= '1;
      trim1    <= '0;
      trim4    <= '0;
    end else begin
      if (stb.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      if (stb.loadTx)  txReg <= readByte;
      else if (stb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b1};
      if (stb.setAddr) regAddr <= shiftReg;
      if (stb.writeReg) begin
        if (regAddr == ADDR_CTRL)  ctrlReg <= shiftReg[NUM_LDO-1:0];
        if (regAddr == ADDR_TRIM1) trim1   <= shiftReg[T1_LSB +: T1_W];
        if (regAddr == ADDR_TRIM4) trim4   <= shiftReg[T4_LSB +: T4_W];
      end
    end
  end

  always_comb begin
    readByte = '0;
    if (regAddr == ADDR_CTRL)       readByte[NUM_LDO-1:0]     = ctrlReg;
    else if (regAddr == ADDR_TRIM1) readByte[T1_LSB +: T1_W]  = trim1;
    else if (regAddr == ADDR_TRIM4) readByte[T4_LSB +: T4_W]  = trim4;
    else                            readByte                  = '1;
  end

  assign rxByte  = shiftReg;
  assign txMsb   = txReg[BYTE_W-1];
  assign ldoEn   = ctrlReg;
  assign ldo1Sel = trim1[3];
  assign ldo2Sel = trim1[2];
  assign ldo3Sel = trim1[1:0];
  assign ldo4Sel = trim4;

  // R8: register state moves only on a write strobe from the control
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeReg |=> $stable({ctrlReg, trim1, trim4}));
endmodule

// File: rtl/pmic_i2c_slave.sv
module pmic_i2c_slave
  import pmic_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [3:0] ldoEn,
  output logic       ldo1Sel,
  output logic       ldo2Sel,
  output logic [1:0] ldo3Sel,
  output logic [1:0] ldo4Sel
);
  dpStrobe_t         stb;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb, sdaBit;

  pmic_i2c_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .sdaBit(sdaBit), .stb(stb), .sdaOe(sdaOe)
  );

  pmic_i2c_regs #(.NUM_LDO(4)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit),
    .rxByte(rxByte), .txMsb(txMsb), .ldoEn(ldoEn),
    .ldo1Sel(ldo1Sel), .ldo2Sel(ldo2Sel), .ldo3Sel(ldo3Sel), .ldo4Sel(ldo4Sel)
  );
endmodule

// File: tb/pmic_i2c_slave_test.sv
module pmic_i2c_slave_test;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b1001000;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, ldo1Sel, ldo2Sel;
  logic [3:0] ldoEn;
  logic [1:0] ldo3Sel, ldo4Sel;
  wire sdaLine = sdaDrv & ~sdaOe;
  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] ctrlM = 4'hF, t1M = 4'h0;
  logic [1:0] t4M = 2'h0;

  always #5 clk = ~clk;

  pmic_i2c_slave uut (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .ldoEn(ldoEn), .ldo1Sel(ldo1Sel), .ldo2Sel(ldo2Sel),
    .ldo3Sel(ldo3Sel), .ldo4Sel(ldo4Sel));

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaDrv = 1; waitC(Q); scl = 1; waitC(Q); sdaDrv = 0; waitC(Q); scl = 0; waitC(Q);
  endtask
  task automatic busStop();
    sdaDrv = 0; waitC(Q); scl = 1; waitC(Q); sdaDrv = 1; waitC(Q);
  endtask
  task automatic putBit(input logic b);
    sdaDrv = b; waitC(Q); scl = 1; waitC(Q); scl = 0; waitC(Q);
  endtask
  task automatic getBit(output logic b);
    sdaDrv = 1; waitC(Q); scl = 1; waitC(Q/2); b = sdaLine; waitC(Q/2); scl = 0; waitC(Q);
  endtask
  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(b);
    ack = ~b;
  endtask
  task automatic recvByte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin getBit(b); d[i] = b; end
    putBit(1'b1);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d, input string req);
    logic k0, k1, k2;
    busStart(); sendByte({DEV, 1'b0}, k0); sendByte(a, k1); sendByte(d, k2); busStop();
    chk({req, " R10 write acks"}, {k0, k1, k2}, 3'b111);
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    logic k0, k1, k2;
    busStart(); sendByte({DEV, 1'b0}, k0); sendByte(a, k1);
    busStart(); sendByte({DEV, 1'b1}, k2); recvByte(d); busStop();
    chk("R2 R10 read acks", {k0, k1, k2}, 3'b111);
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h00:   return {4'b0, ctrlM};
      8'h08:   return {3'b0, t1M, 1'b0};
      8'h0A:   return {4'b0, t4M, 2'b0};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) ctrlM = d[3:0];
    else if (a == 8'h08) t1M = d[4:1];
    else if (a == 8'h0A) t4M = d[3:2];
  endtask

  task automatic checkOuts(input string req);
    chk({req, " enables"}, ldoEn, ctrlM);
    chk({req, " selects"}, {ldo1Sel, ldo2Sel, ldo3Sel, ldo4Sel}, {t1M, t4M});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, a, d;
    logic k0, k1, k2;
    int unused;
    unused = $urandom(32'd20240611);
    waitC(5); rstN = 1; waitC(5);
    // R1 reset state
    chk("R1 enables", ldoEn, 4'hF);
    chk("R1 selects", {ldo1Sel, ldo2Sel, ldo3Sel, ldo4Sel}, 6'h0);
    chk("R1 oe", sdaOe, 1'b0);

    // R3 directed enable write, then R4, R5 with all-ones to exercise masking (R6)
    writeReg(8'h00, 8'hF5, "R3"); modelWrite(8'h00, 8'hF5); checkOuts("R3");
    writeReg(8'h08, 8'hFF, "R4"); modelWrite(8'h08, 8'hFF); checkOuts("R4");
    readReg(8'h08, rd); chk("R6 trim1 masked readback", rd, 8'h1E);
    writeReg(8'h0A, 8'hFF, "R5"); modelWrite(8'h0A, 8'hFF); checkOuts("R5");
    readReg(8'h0A, rd); chk("R6 trim4 masked readback", rd, 8'h0C);
    readReg(8'h00, rd); chk("R6 ctrl readback", rd, 8'h05);

    // R7 unmapped read, R8 unmapped write
    readReg(8'h01, rd); chk("R7 unmapped read", rd, 8'hFF);
    writeReg(8'h09, 8'h00, "R8"); checkOuts("R8 unmapped write");

    // R2 foreign address: not acknowledged, following bytes ignored
    busStart(); sendByte({7'b1001001, 1'b0}, k0); sendByte(8'h00, k1); sendByte(8'h00, k2); busStop();
    chk("R2 foreign address nack", k0, 1'b0);
    chk("R2 ignored bytes nack", {k1, k2}, 2'b00);
    checkOuts("R2 foreign write ignored");

    // R9 abort in the middle of a data byte
    busStart(); sendByte({DEV, 1'b0}, k0); sendByte(8'h00, k1);
    putBit(1'b0); putBit(1'b0); putBit(1'b0); busStop();
    checkOuts("R9 stop mid byte");
    busStart(); sendByte({DEV, 1'b0}, k0); sendByte(8'h08, k1);
    putBit(1'b0); putBit(1'b0); busStart(); sendByte({DEV, 1'b1}, k2); recvByte(rd); busStop();
    chk("R9 start mid byte then read", rd, expRead(8'h08));
    checkOuts("R9 start mid byte");

    // random traffic
    for (int i = 0; i < 30; i++) begin
      case ($urandom % 4)
        0: a = 8'h00;
        1: a = 8'h08;
        2: a = 8'h0A;
        default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      writeReg(a, d, "R3 R4 R5 R8 random");
      modelWrite(a, d);
      checkOuts("R3 R4 R5 R8 random outputs");
      readReg(a, rd);
      chk("R6 R7 random readback", rd, expRead(a));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule